// File: doc/BRIEF.md
# Region Access Policy Checker

This block decides, for every bus request, whether the requesting domain may perform that read or write at the given address. It keeps a small table of region descriptors. Each descriptor holds an inclusive address range aligned to 4 KB pages, a 3-bit policy code for each domain, a valid flag and a lock flag. A request is allowed when at least one valid descriptor covers the address and grants the requested kind of access to the requesting domain.

A single configuration write port programs the descriptors and the global control. Checking is switched on in two steps. The first write arms the block and a second write commits. Until the commit, and again after checking has been turned off, every request is allowed.

The global enable is a three-state machine. In GV_OFF checking is bypassed. The transition arm moves GV_OFF to GV_ARMED on a control write with mode=1. In GV_ARMED checking is still bypassed. The transition commit moves GV_ARMED to GV_ON on a control write with mode=1 and commit=1. The transition disable moves any state back to GV_OFF on a control write with mode=0. In GV_ON policies are enforced.

Top module: `rac_checker`

## Requirements
- R1: After reset, resp_valid and resp_allow are 0, the global state is GV_OFF, and every descriptor is invalid, unlocked, has all policies 0 and covers 0x00000000 to 0xFFFFFFFF.
- R2: A descriptor write with cfg_word=2 loads the policies of domains 0 to 7, where domain n sits in cfg_wdata[3n+2:3n]. A write with cfg_word=3 loads domains 8 to 15, where domain n sits in cfg_wdata[3(n-8)+2:3(n-8)].
- R3: Policy code 0 grants nothing, 1 grants reads only, 2 grants writes only, and 3 to 7 grant both reads and writes.
- R4: A region covers addresses from start to end inclusive. Writing the start (cfg_word=0) stores the data with its low 12 bits cleared. Writing the end (cfg_word=1) stores the data with its low 12 bits set.
- R5: cfg_wdata[31] of a cfg_word=3 write is the descriptor valid flag. Invalid descriptors never grant access. With checking on, a request that no valid descriptor covers is denied.
- R6: When several valid descriptors cover an address, the request is allowed if any one of them grants it.
- R7: A control write (cfg_glob=1) uses cfg_wdata[0] as mode and cfg_wdata[1] as commit. Checking is enforced only in GV_ON, which is reached from GV_ARMED by a write with mode=1 and commit=1. A write with mode=1 in GV_OFF only arms, whatever the commit bit. Outside GV_ON every request is allowed.
- R8: A control write with mode=0 returns the global state to GV_OFF from any state, after which all requests are allowed.
- R9: cfg_wdata[28] of a cfg_word=3 write is the lock flag. Once a descriptor is locked, every later write to any of its words is ignored until reset.
- R10: resp_valid is req_valid delayed by one clock. resp_allow carries the decision for that request and is 0 whenever resp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_glob | input | 1 | 1 selects the global control, 0 selects a descriptor word |
| cfg_region | input | RIDX_W | Descriptor index for a descriptor write |
| cfg_word | input | 2 | Descriptor word: 0 start, 1 end, 2 policies low, 3 policies high with flags |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_dom | input | 4 | Requesting domain ID |
| req_write | input | 1 | 1 for write, 0 for read |
| resp_valid | output | 1 | Decision present, one cycle after the request |
| resp_allow | output | 1 | 1 when the request is allowed |

## Verification
A wrong global state shows up on the very next response. If the machine jumps to GV_ON without a commit, an uncovered request is denied instead of allowed. If it fails to leave GV_ON, a request issued after a disable write is denied. A stored policy in the wrong bit slot, an unforced page offset or a lost lock shows as a flipped resp_allow one cycle after a request that probes that domain, range edge or rewritten descriptor. The stimulus therefore probes each domain slot, both range boundaries from each side, and a rewrite of a locked descriptor.

// File: rtl/rac_pkg.sv
package rac_pkg;
    localparam int POL_W         = 3;
    localparam int DOMS_PER_WORD = 8;
    localparam int WORD_W        = 32;
    localparam int PAGE_BITS     = 12;
    localparam int LOCK_BIT      = 28;
    localparam int VALID_BIT     = 31;
    localparam int POL_FIELD_W   = POL_W * DOMS_PER_WORD;

    typedef enum logic [1:0] {
        GV_OFF   = 2'd0,
        GV_ARMED = 2'd1,
        GV_ON    = 2'd2
    } gv_state_e;

    typedef enum logic [1:0] {
        W_START  = 2'd0,
        W_END    = 2'd1,
        W_POL_LO = 2'd2,
        W_POL_HI = 2'd3
    } word_sel_e;

    function automatic logic pol_grants(input logic [POL_W-1:0] pol, input logic is_write);
        logic ok;
        unique case (pol)
            3'd0:    ok = 1'b0;
            3'd1:    ok = !is_write;
            3'd2:    ok = is_write;
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/rac_gv_fsm.sv
module rac_gv_fsm
    import rac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic ctl_mode,
    input  logic ctl_commit,
    output logic gv_on
);
    gv_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GV_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctl_we) begin
            if (!ctl_mode) begin
                state_d = GV_OFF;
            end else begin
                unique case (state_q)
                    GV_OFF:   state_d = GV_ARMED;
                    GV_ARMED: state_d = ctl_commit ? GV_ON : GV_ARMED;
                    GV_ON:    state_d = GV_ON;
                    default:  state_d = GV_OFF;
                endcase
            end
        end
    end

    always_comb begin
        gv_on = (state_q == GV_ON);
    end
endmodule

// File: rtl/rac_desc_bank.sv
module rac_desc_bank
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32,
    localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RIDX_W-1:0]      wr_region,
    input  logic [1:0]             wr_word,
    input  logic [WORD_W-1:0]      wr_data,
    output logic [ADDR_W-1:0]      start_q  [NUM_REGIONS],
    output logic [ADDR_W-1:0]      end_q    [NUM_REGIONS],
    output logic [POL_FIELD_W-1:0] pol_lo_q [NUM_REGIONS],
    output logic [POL_FIELD_W-1:0] pol_hi_q [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] valid_q,
    output logic [NUM_REGIONS-1:0] lock_q
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_BITS) - 1);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_desc
        logic hit_w;
        assign hit_w = wr_en && (wr_region == RIDX_W'(r)) && !lock_q[r];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_q[r]  <= '0;
                end_q[r]    <= '1;
                pol_lo_q[r] <= '0;
                pol_hi_q[r] <= '0;
                valid_q[r]  <= 1'b0;
                lock_q[r]   <= 1'b0;
            end else if (hit_w) begin
                unique case (word_sel_e'(wr_word))
                    W_START:  start_q[r]  <= wr_data[ADDR_W-1:0] & ~PAGE_MASK;
                    W_END:    end_q[r]    <= wr_data[ADDR_W-1:0] | PAGE_MASK;
                    W_POL_LO: pol_lo_q[r] <= wr_data[POL_FIELD_W-1:0];
                    W_POL_HI: begin
                        pol_hi_q[r] <= wr_data[POL_FIELD_W-1:0];
                        valid_q[r]  <= wr_data[VALID_BIT];
                        lock_q[r]   <= wr_data[LOCK_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rac_match.sv
module rac_match
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int NUM_DOMAINS = 16,
    parameter int ADDR_W      = 32
) (
    input  logic [ADDR_W-1:0]      start_q  [NUM_REGIONS],
    input  logic [ADDR_W-1:0]      end_q    [NUM_REGIONS],
    input  logic [POL_FIELD_W-1:0] pol_lo_q [NUM_REGIONS],
    input  logic [POL_FIELD_W-1:0] pol_hi_q [NUM_REGIONS],
    input  logic [NUM_REGIONS-1:0] valid_q,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [3:0]             dom,
    input  logic                   is_write,
    output logic                   permit
);
    logic [NUM_REGIONS-1:0] grant;
    logic                   dom_ok;

    assign dom_ok = (32'(dom) < NUM_DOMAINS);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
        logic [POL_W-1:0] pol;
        logic             in_range;
        always_comb begin
            pol      = dom[3] ? pol_hi_q[r][dom[2:0]*POL_W +: POL_W]
                              : pol_lo_q[r][dom[2:0]*POL_W +: POL_W];
            in_range = (addr >= start_q[r]) && (addr <= end_q[r]);
            grant[r] = valid_q[r] && in_range && dom_ok && pol_grants(pol, is_write);
        end
    end

    assign permit = |grant;
endmodule

// File: rtl/rac_checker.sv
module rac_checker
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int NUM_DOMAINS = 16,
    parameter int ADDR_W      = 32,
    localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_glob,
    input  logic [RIDX_W-1:0] cfg_region,
    input  logic [1:0]        cfg_word,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_dom,
    input  logic              req_write,
    output logic              resp_valid,
    output logic              resp_allow
);
    logic [ADDR_W-1:0]      start_q  [NUM_REGIONS];
    logic [ADDR_W-1:0]      end_q    [NUM_REGIONS];
    logic [POL_FIELD_W-1:0] pol_lo_q [NUM_REGIONS];
    logic [POL_FIELD_W-1:0] pol_hi_q [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] valid_q;
    logic [NUM_REGIONS-1:0] lock_q;
    logic                   gv_on;
    logic                   permit;
    logic                   decision;

    rac_gv_fsm u_gv (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (cfg_we && cfg_glob),
        .ctl_mode   (cfg_wdata[0]),
        .ctl_commit (cfg_wdata[1]),
        .gv_on      (gv_on)
    );

    rac_desc_bank #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we && !cfg_glob),
        .wr_region (cfg_region),
        .wr_word   (cfg_word),
        .wr_data   (cfg_wdata),
        .start_q   (start_q),
        .end_q     (end_q),
        .pol_lo_q  (pol_lo_q),
        .pol_hi_q  (pol_hi_q),
        .valid_q   (valid_q),
        .lock_q    (lock_q)
    );

    rac_match #(.NUM_REGIONS(NUM_REGIONS), .NUM_DOMAINS(NUM_DOMAINS), .ADDR_W(ADDR_W)) u_match (
        .start_q  (start_q),
        .end_q    (end_q),
        .pol_lo_q (pol_lo_q),
        .pol_hi_q (pol_hi_q),
        .valid_q  (valid_q),
        .addr     (req_addr),
        .dom      (req_dom),
        .is_write (req_write),
        .permit   (permit)
    );

    assign decision = !gv_on || permit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && decision;
        end
    end
endmodule

// File: rtl/rac_checker_chk.sv
module rac_checker_chk #(
    parameter int NUM_REGIONS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   cfg_glob,
    input logic [31:0]            cfg_wdata,
    input logic                   req_valid,
    input logic                   resp_valid,
    input logic                   resp_allow,
    input logic                   gv_on,
    input logic [NUM_REGIONS-1:0] lock_q
);
    // R10
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_allow));

    // R7
    bypass_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !gv_on) |=> resp_allow);

    // R7
    commit_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gv_on) |-> $past(cfg_we && cfg_glob && cfg_wdata[0] && cfg_wdata[1]));

    // R8
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_glob && !cfg_wdata[0]) |=> !gv_on);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_lock
        // R9
        lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[r] |=> lock_q[r]);
    end
endmodule

bind rac_checker rac_checker_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_glob   (cfg_glob),
    .cfg_wdata  (cfg_wdata),
    .req_valid  (req_valid),
    .resp_valid (resp_valid),
    .resp_allow (resp_allow),
    .gv_on      (gv_on),
    .lock_q     (lock_q)
);

// File: tb/rac_checker_test.sv
module rac_checker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_glob = 1'b0;
    logic [1:0]  cfg_region = '0;
    logic [1:0]  cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_dom = '0;
    logic        req_write = 1'b0;
    logic        resp_valid;
    logic        resp_allow;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rac_checker uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_glob(cfg_glob),
        .cfg_region(cfg_region), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_dom(req_dom),
        .req_write(req_write), .resp_valid(resp_valid), .resp_allow(resp_allow)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic cfg_write(input bit glob, input int region, input int word, input logic [31:0] data);
        @(negedge clk);
        cfg_we     = 1'b1;
        cfg_glob   = glob;
        cfg_region = 2'(region);
        cfg_word   = 2'(word);
        cfg_wdata  = data;
        @(negedge clk);
        cfg_we     = 1'b0;
    endtask

    task automatic send_req(input logic [31:0] addr, input int dom, input bit wr,
                            input bit exp_allow, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_dom   = 4'(dom);
        req_write = wr;
        exp_q.push_back(exp_allow);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pops one expected decision per response
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && resp_valid) begin
                n_tests++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected response: actual resp_valid=1 expected 0");
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (resp_allow !== e) begin
                        n_fail++;
                        $display("FAIL %s: actual resp_allow=%0b expected %0b", t, resp_allow, e);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        n_tests++;
        if (resp_valid !== 1'b0 || resp_allow !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %0b%0b expected 00", resp_valid, resp_allow);
        end

        // R1/R7: global off after reset, everything allowed
        send_req(32'h0000_5000, 0, 1'b0, 1'b1, "R1 bypass after reset");

        // Region 0: unaligned start/end forced to pages (R4)
        cfg_write(1'b0, 0, 0, 32'h0000_1234);
        cfg_write(1'b0, 0, 1, 32'h0000_1000);
        // R2 low word: d1=1 [5:3], d2=2 [8:6], d3=7 [11:9]
        cfg_write(1'b0, 0, 2, 32'h0000_0E88);
        // R2 high word: d9=3 [5:3], valid bit 31 (R5)
        cfg_write(1'b0, 0, 3, 32'h8000_0018);

        // R7: arm only, still bypassed
        cfg_write(1'b1, 0, 0, 32'h1);
        send_req(32'h0000_5000, 0, 1'b0, 1'b1, "R7 armed still bypass");
        // R7: commit
        cfg_write(1'b1, 0, 0, 32'h3);

        send_req(32'h0000_5000, 0, 1'b0, 1'b0, "R5 no match denied");
        send_req(32'h0000_1800, 1, 1'b0, 1'b1, "R3 read-only read");
        send_req(32'h0000_1800, 1, 1'b1, 1'b0, "R3 read-only write");
        send_req(32'h0000_1800, 2, 1'b1, 1'b1, "R3 write-only write");
        send_req(32'h0000_1800, 2, 1'b0, 1'b0, "R3 write-only read");
        send_req(32'h0000_1800, 3, 1'b1, 1'b1, "R3 code 7 write");
        send_req(32'h0000_1800, 0, 1'b0, 1'b0, "R3 code 0 read");
        send_req(32'h0000_1800, 9, 1'b1, 1'b1, "R2 domain 9 high word");
        send_req(32'h0000_1800, 8, 1'b0, 1'b0, "R2 domain 8 high word");
        send_req(32'h0000_1000, 1, 1'b0, 1'b1, "R4 start forced aligned");
        send_req(32'h0000_0FFF, 1, 1'b0, 1'b0, "R4 below start");
        send_req(32'h0000_1FFF, 1, 1'b0, 1'b1, "R4 end forced to page top");
        send_req(32'h0000_2000, 1, 1'b0, 1'b0, "R4 above end");

        // R6: region 1 full range, d0=3, valid + lock (bit 28, R9)
        cfg_write(1'b0, 1, 2, 32'h0000_0003);
        cfg_write(1'b0, 1, 3, 32'h9000_0000);
        send_req(32'h0000_1800, 0, 1'b0, 1'b1, "R6 overlap any grants");
        send_req(32'hFFFF_F000, 0, 1'b1, 1'b1, "R6 full range top");

        // R9: writes to locked region 1 are ignored
        cfg_write(1'b0, 1, 2, 32'h0000_0000);
        cfg_write(1'b0, 1, 3, 32'h0000_0000);
        cfg_write(1'b0, 1, 0, 32'h0001_0000);
        send_req(32'h0000_5000, 0, 1'b0, 1'b1, "R9 locked policy kept");
        send_req(32'h0000_1800, 0, 1'b1, 1'b1, "R9 locked range kept");

        // R5: invalidate region 0, only region 1 (d1=0) covers
        cfg_write(1'b0, 0, 3, 32'h0000_0018);
        send_req(32'h0000_1800, 1, 1'b0, 1'b0, "R5 invalid descriptor ignored");

        // R8: disable
        cfg_write(1'b1, 0, 0, 32'h0);
        send_req(32'h0000_1800, 1, 1'b0, 1'b1, "R8 disabled allows");
        // R7: mode+commit from off only arms
        cfg_write(1'b1, 0, 0, 32'h3);
        send_req(32'h0000_1800, 1, 1'b0, 1'b1, "R7 commit without arm");
        cfg_write(1'b1, 0, 0, 32'h3);
        send_req(32'h0000_1800, 1, 1'b0, 1'b0, "R7 second commit enforces");

        // R10: idle cycles give no response
        repeat (3) @(negedge clk);
        n_tests++;
        if (resp_valid !== 1'b0 || resp_allow !== 1'b0 || exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 idle: actual valid=%0b allow=%0b pending=%0d expected 0 0 0",
                     resp_valid, resp_allow, exp_q.size());
        end
        finish_run();
    end
endmodule